// File: doc/BRIEF.md
# UART Receive FIFO

This block holds the characters delivered by a UART receiver until the bus side reads them. Each stored word is 12 bits wide. Bits 7:0 hold the character. Bits 11:8 hold its error indications: bit 8 is framing, bit 9 is parity, bit 10 is break and bit 11 is overrun. The receiver pushes words through a valid/ready port, or signals a line break. A data-register read pops the oldest word. The popped word's error bits are kept in a status register.

A configuration write carries the FIFO-enable setting. When the FIFO is enabled the buffer holds 16 words. When it is disabled the buffer acts as a single-character holding register. Any configuration write that changes the enable setting discards the buffered contents.

The block also drives the receive-empty and receive-full flags and a receive interrupt request. The interrupt trigger level is a fixed count of one.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, rx_empty=1, rx_full=0, rx_irq=0, rx_status=0, push_ready=1 and fifo_en=0.
- R2: With the FIFO enabled, words are returned on pop_word in the order they were pushed, including after the internal read position wraps past entry 15.
- R3: With the FIFO enabled, push_ready stays 1 until 16 words are held, and rx_full is 1 exactly when 16 words are held. With it disabled, one held word makes rx_full=1 and push_ready=0.
- R4: rx_empty is 1 exactly when no word is held. rx_flags carries rx_full at bit 6 and rx_empty at bit 4, and its other bits are 0.
- R5: rx_irq rises when a push takes the count from 0 to 1. It falls when a pop takes the count to 0.
- R6: A pop of a held word loads its bits 11:8 into rx_status[3:0]. stat_clr clears rx_status.
- R7: A push_brk pulse enters the word 0x400, which is the break bit set with zero data. It takes priority over push_valid in the same cycle.
- R8: A push while push_ready=0 is dropped and leaves the held contents unchanged. It sets an overrun indication that shows as rx_status[3] until stat_clr.
- R9: A push and a pop in the same cycle with at least one word held leave the count unchanged. The oldest word leaves and the new word is appended.
- R10: A pop while the buffer is empty changes neither the count nor rx_status.
- R11: A cfg_wr whose cfg_fifo_en differs from fifo_en empties the buffer, sets rx_empty and clears rx_irq. A cfg_wr with the same value leaves the contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Receiver offers push_word |
| push_word | input | 12 | Character in bits 7:0, error bits in bits 11:8 |
| push_brk | input | 1 | Receiver reports a line break |
| push_ready | output | 1 | Buffer can accept a word |
| pop | input | 1 | Data-register read strobe |
| pop_word | output | 12 | Oldest held word |
| stat_clr | input | 1 | Clears rx_status and the overrun indication |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_fifo_en | input | 1 | FIFO-enable value carried by cfg_wr |
| fifo_en | output | 1 | Current FIFO-enable setting |
| rx_empty | output | 1 | No word held |
| rx_full | output | 1 | Buffer at capacity |
| rx_flags | output | 8 | Flag byte: bit 6 full, bit 4 empty |
| rx_irq | output | 1 | Receive interrupt request |
| rx_status | output | 4 | Error bits of the last popped word; bit 3 also shows overrun |

## Verification
Several properties are checked on every cycle:
- the count never exceeds capacity, and the disabled mode never holds more than one word;
- a dropped push leaves the count unchanged and raises the overrun bit;
- an enable change empties the buffer;
- the interrupt rises and falls on the 0/1 count boundary.

Word ordering across pointer wrap, status loading from popped entries, the break word, and same-cycle push and pop can only be shown by the bench scenarios, which compare data values. The bench sweeps every fill level from 1 to 16.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4,
  parameter int TRIG   = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push_valid,
  input  logic [DATA_W+ERR_W-1:0] push_word,
  input  logic                    push_brk,
  output logic                    push_ready,
  input  logic                    pop,
  output logic [DATA_W+ERR_W-1:0] pop_word,
  input  logic                    stat_clr,
  input  logic                    cfg_wr,
  input  logic                    cfg_fifo_en,
  output logic                    fifo_en,
  output logic                    rx_empty,
  output logic                    rx_full,
  output logic [7:0]              rx_flags,
  output logic                    rx_irq,
  output logic [ERR_W-1:0]        rx_status
);
  localparam int W   = DATA_W + ERR_W;
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam logic [W-1:0] BRK_WORD = W'(1) << (DATA_W + 2);

  logic [W-1:0]     mem [DEPTH];
  logic [PW-1:0]    rptr;
  logic [CW-1:0]    cnt, cnt_nx, cap;
  logic [ERR_W-1:0] st_q;
  logic             ovr_q;

  wire          flush    = cfg_wr && (cfg_fifo_en != fifo_en);
  wire          push     = push_valid || push_brk;
  wire [W-1:0]  in_word  = push_brk ? BRK_WORD : push_word;
  wire          push_acc = push && push_ready && !flush;
  wire          pop_acc  = pop && (cnt != 0) && !flush;
  wire [PW-1:0] wptr     = rptr + PW'(cnt);

  assign cap        = fifo_en ? CW'(DEPTH) : CW'(1);
  assign push_ready = cnt < cap;
  assign rx_empty   = cnt == 0;
  assign rx_full    = cnt == cap;
  assign rx_flags   = {1'b0, rx_full, 1'b0, rx_empty, 4'b0};
  assign pop_word   = mem[rptr];
  assign rx_status  = {st_q[ERR_W-1] | ovr_q, st_q[ERR_W-2:0]};
  assign cnt_nx     = cnt + CW'(push_acc) - CW'(pop_acc);

  always_ff @(posedge clk) begin
    if (push_acc) mem[wptr] <= in_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr    <= '0;
      cnt     <= '0;
      fifo_en <= 1'b0;
      rx_irq  <= 1'b0;
      st_q    <= '0;
      ovr_q   <= 1'b0;
    end else begin
      if (cfg_wr) fifo_en <= cfg_fifo_en;
      if (flush) begin
        rptr   <= '0;
        cnt    <= '0;
        rx_irq <= 1'b0;
      end else begin
        cnt <= cnt_nx;
        if (pop_acc) rptr <= rptr + 1'b1;
        if (push_acc && cnt_nx == CW'(TRIG)) rx_irq <= 1'b1;
        else if (pop_acc && cnt_nx == CW'(TRIG - 1)) rx_irq <= 1'b0;
      end
      if (stat_clr) begin
        st_q  <= '0;
        ovr_q <= 1'b0;
      end else begin
        if (pop_acc) st_q <= pop_word[W-1:DATA_W];
        if (push && !push_ready) ovr_q <= 1'b1;
      end
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_single_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> cnt <= 1);
  assert_drop_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !push_ready && !pop && !cfg_wr) |=> cnt == $past(cnt));
  assert_drop_sets_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !push_ready && !stat_clr) |=> rx_status[ERR_W-1]);
  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rx_empty && !rx_irq));
  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && rx_empty && !cfg_wr) |=> rx_irq);
  assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt == 1 && !push && !cfg_wr) |=> !rx_irq);
  assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && rx_empty && !push && !cfg_wr && !stat_clr) |=> (rx_empty && $stable(rx_status)));
endmodule

// File: tb/uart_rx_fifo_tb_top.sv
module uart_rx_fifo_tb_top;
  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_brk = 0, pop = 0, stat_clr = 0, cfg_wr = 0, cfg_fifo_en = 0;
  logic [11:0] push_word = 0;
  logic push_ready, fifo_en, rx_empty, rx_full, rx_irq;
  logic [11:0] pop_word;
  logic [7:0] rx_flags;
  logic [3:0] rx_status;
  int checks = 0, fails = 0;
  logic [11:0] q [$];

  always #2.5 clk = ~clk;

  uart_rx_fifo dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    push_valid = 0; push_brk = 0; pop = 0; stat_clr = 0; cfg_wr = 0;
  endtask

  task automatic do_push(logic [11:0] w);
    push_valid = 1; push_word = w; cyc();
  endtask

  task automatic do_pop();
    pop = 1; cyc();
  endtask

  task automatic do_cfg(logic en);
    cfg_wr = 1; cfg_fifo_en = en; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [11:0] w;
    repeat (3) @(posedge clk); #1; rst_n = 1;
    chk("R1 empty", rx_empty, 1); chk("R1 full", rx_full, 0);
    chk("R1 irq", rx_irq, 0); chk("R1 status", rx_status, 0);
    chk("R1 ready", push_ready, 1); chk("R1 en", fifo_en, 0);
    chk("R4 flags reset", rx_flags, 8'h10);

    do_cfg(1);
    chk("R11 en", fifo_en, 1); chk("R11 empty", rx_empty, 1);

    for (int n = 1; n <= 16; n++) begin
      for (int i = 0; i < n; i++) begin
        w = {1'b0, 3'(i + n), 8'(n * 17 + i)};
        do_push(w);
        chk("R3 ready", push_ready, (i + 1 < 16));
        chk("R3 full", rx_full, (i + 1 == 16));
        chk("R4 empty", rx_empty, 0);
        chk("R5 irq up", rx_irq, 1);
      end
      chk("R4 flags", rx_flags, (n == 16) ? 8'h40 : 8'h00);
      for (int i = 0; i < n; i++) begin
        w = {1'b0, 3'(i + n), 8'(n * 17 + i)};
        chk("R2 order", pop_word, w);
        do_pop();
        chk("R6 status", rx_status, {1'b0, w[10:8]});
        chk("R4 empty after pop", rx_empty, (i + 1 == n));
        chk("R5 irq", rx_irq, (i + 1 < n));
      end
    end

    for (int i = 0; i < 16; i++) do_push(12'h0A0 + 12'(i));
    push_brk = 1; cyc();
    chk("R8 overrun", rx_status[3], 1);
    chk("R8 still full", rx_full, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R8 contents", pop_word, 12'h0A0 + 12'(i));
      do_pop();
    end
    chk("R8 drained", rx_empty, 1);
    chk("R8 ovr held", rx_status[3], 1);
    stat_clr = 1; cyc();
    chk("R6 clear", rx_status, 0);

    do_push(12'h111);
    for (int i = 0; i < 5; i++) begin
      push_valid = 1; push_word = 12'h200 + 12'(i); pop = 1;
      w = pop_word;
      cyc();
      chk("R9 word", w, (i == 0) ? 12'h111 : 12'h200 + 12'(i - 1));
      chk("R9 count", rx_empty, 0); chk("R9 full", rx_full, 0);
    end
    chk("R9 last", pop_word, 12'h204);
    do_pop();
    chk("R9 empty", rx_empty, 1);

    stat_clr = 1; cyc();
    do_pop();
    chk("R10 empty", rx_empty, 1); chk("R10 status", rx_status, 0);
    chk("R10 irq", rx_irq, 0);

    push_brk = 1; push_valid = 1; push_word = 12'h0FF; cyc();
    chk("R7 word", pop_word, 12'h400);
    do_pop();
    chk("R7 status", rx_status, 4'b0100);
    chk("R7 empty", rx_empty, 1);

    do_push(12'h031); do_push(12'h032); do_push(12'h033);
    do_cfg(1);
    chk("R11 same keeps", rx_empty, 0);
    chk("R11 same word", pop_word, 12'h031);
    do_cfg(0);
    chk("R11 flush empty", rx_empty, 1); chk("R11 flush irq", rx_irq, 0);
    chk("R11 en off", fifo_en, 0);

    stat_clr = 1; cyc();
    do_push(12'h05A);
    chk("R3 off full", rx_full, 1); chk("R3 off ready", push_ready, 0);
    chk("R4 off flags", rx_flags, 8'h40);
    do_push(12'h05B);
    chk("R8 off overrun", rx_status[3], 1);
    chk("R8 off word", pop_word, 12'h05A);
    do_pop();
    chk("R3 off empty", rx_empty, 1); chk("R3 off ready2", push_ready, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule